// File: doc/BRIEF.md
# Adjustable PTP real-time clock

This block is a hardware time-of-day counter for precision time protocol work. It keeps three values: a seconds count, a nanoseconds count and a 32-bit sub-nanosecond fraction. Every enabled clock cycle is one tick of the 25 MHz reference, and each tick adds a nominal 40 ns. A signed rate trim feeds a 30-bit magnitude into the fraction on every tick. A carry out of the fraction makes that tick 41 ns, and a borrow makes it 39 ns. This lets software pull the clock's frequency in steps finer than a nanosecond.

Software reaches the clock through a small synchronous register bus. The control register carries two kinds of bits. Sticky enables turn on the clock and the trim. One-shot commands snapshot the live time into shadow registers, load the shadow time into the clock, step the clock by the shadow amount in either direction, or clear the time. Commands act on the cycle after the write that sets them. A snapshot returns seconds, nanoseconds and a 3-bit phase as one consistent set. The phase counts in units of 8 ns on top of the nanoseconds.

Top module: `rtc_trim_clock`

## Requirements
- R1: After reset the live seconds, nanoseconds and phase are zero, and every mapped register reads zero.
- R2: With the clock enable (control bit 1) set and no trim, each cycle adds 40 to nanoseconds. With it clear and no command pending, the time holds.
- R3: When nanoseconds reach 1,000,000,000 they wrap, and one second is carried into the seconds count.
- R4: With trim enable (control bit 2) set and rate bit 31 = 1, each tick adds rate bits 29:0 to the 32-bit fraction. A tick whose addition carries out of the fraction advances 41 ns.
- R5: With trim enabled and rate bit 31 = 0, each tick subtracts the magnitude from the fraction. A tick that borrows advances 39 ns.
- R6: With trim enable clear, the rate register has no effect and each tick is exactly 40 ns.
- R7: Writing control bit 4 (read time) copies the live seconds, nanoseconds and phase into the shadow registers on the next cycle. Software reads them at offsets 0x08, 0x04 and 0x02.
- R8: Writing control bit 3 (load time) puts the shadow seconds, nanoseconds and phase into the live clock on the next cycle. No tick is added in that cycle, and the fraction is cleared.
- R9: Writing control bit 6 (step) with bit 5 = 1 adds the shadow seconds and nanoseconds to the live time on the next cycle. That cycle's tick is added too, and a nanosecond overflow carries into seconds.
- R10: A step with bit 5 = 0 subtracts the shadow seconds and nanoseconds. A nanosecond underflow adds 1,000,000,000 back and borrows one second.
- R11: Writing control bit 0 (clock reset) clears seconds, nanoseconds, phase and fraction on the next cycle. The enable bits keep their values.
- R12: Command bits 0, 3, 4 and 6 are one-shot. The control register reads back only step direction (bit 5), trim enable (bit 2) and clock enable (bit 1).
- R13: The map is: control 0x00, phase 0x02, nanoseconds 0x04, seconds 0x08 and rate 0x0C. The rate register reads back bit 31 and bits 29:0. Other offsets read zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| time_sec | output | 32 | Live seconds |
| time_ns | output | 30 | Live nanoseconds |
| time_phase | output | 3 | Live phase in 8 ns units |

## Verification
Some behaviours are checked on every cycle by assertions. These are the fraction's carry and borrow matching a 41 or 39 ns tick, the fraction holding while trim is off, and the time holding while stopped. The assertions also cover load and clear landing one cycle after the command, the snapshot matching the previous live time, and commands never appearing without a control write. Other behaviours only the bench's scenarios can show. These are the nanosecond wrap and its carry, and a step's combined seconds and nanoseconds arithmetic with borrow. The bench also shows the exact long-run drift for a given rate word and the register map's readback and ignored offsets. A behavioural model checks the live time on every clock.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

    localparam int DATA_W     = 32;
    localparam int SEC_W      = 32;
    localparam int NS_W       = 30;
    localparam int PH_W       = 3;
    localparam int FRAC_W     = 32;
    localparam int TRIM_W     = 30;
    localparam int INC_W      = 6;
    localparam int NOM_INC    = 40;
    localparam int NS_PER_SEC = 1_000_000_000;
    localparam int SUM_W      = NS_W + 3;

    // control bit positions (software decodes these)
    localparam int CB_CLR  = 0;
    localparam int CB_RUN  = 1;
    localparam int CB_TRIM = 2;
    localparam int CB_LOAD = 3;
    localparam int CB_SNAP = 4;
    localparam int CB_SDIR = 5;
    localparam int CB_STEP = 6;
    localparam int RATE_DIR_BIT = 31;

    // register byte offsets
    localparam int OFS_CTRL  = 'h0;
    localparam int OFS_PHASE = 'h2;
    localparam int OFS_NS    = 'h4;
    localparam int OFS_SEC   = 'h8;
    localparam int OFS_RATE  = 'hC;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
        logic [PH_W-1:0]  ph;
    } rtc_time_t;

    typedef struct packed {
        logic clr;
        logic load;
        logic step;
        logic snap;
    } rtc_cmd_t;

    typedef struct packed {
        logic              run;
        logic              trim_en;
        logic              trim_up;
        logic              step_up;
        logic [TRIM_W-1:0] trim_mag;
    } rtc_cfg_t;

    // carry: 2'b01 = +1 second, 2'b11 = -1 second, 2'b00 = none
    typedef struct packed {
        logic [NS_W-1:0] ns;
        logic [1:0]      carry;
    } ns_fold_t;

    function automatic ns_fold_t fold_ns(input logic signed [SUM_W-1:0] s);
        ns_fold_t r;
        logic signed [SUM_W-1:0] lim;
        lim = $signed(SUM_W'(NS_PER_SEC));
        if (s >= lim) begin
            r.ns    = NS_W'(s - lim);
            r.carry = 2'b01;
        end else if (s < 0) begin
            r.ns    = NS_W'(s + lim);
            r.carry = 2'b11;
        end else begin
            r.ns    = NS_W'(s);
            r.carry = 2'b00;
        end
        return r;
    endfunction

endpackage

// File: rtl/rtc_regbank.sv
module rtc_regbank
    import rtc_trim_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  rtc_time_t         live,
    output logic [DATA_W-1:0] bus_rdata,
    output rtc_cmd_t          cmd,
    output rtc_cfg_t          cfg,
    output rtc_time_t         shadow
);

    localparam logic [ADDR_W-1:0] AD_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] AD_PHASE = ADDR_W'(OFS_PHASE);
    localparam logic [ADDR_W-1:0] AD_NS    = ADDR_W'(OFS_NS);
    localparam logic [ADDR_W-1:0] AD_SEC   = ADDR_W'(OFS_SEC);
    localparam logic [ADDR_W-1:0] AD_RATE  = ADDR_W'(OFS_RATE);

    rtc_cmd_t  cmd_q;
    rtc_cfg_t  cfg_q;
    rtc_time_t shadow_q;
    logic wr_ctrl, wr_ph, wr_ns, wr_sec, wr_rate;
    logic unused_wbits;

    assign unused_wbits = bus_wdata[30];

    assign wr_ctrl = bus_we && (bus_addr == AD_CTRL);
    assign wr_ph   = bus_we && (bus_addr == AD_PHASE);
    assign wr_ns   = bus_we && (bus_addr == AD_NS);
    assign wr_sec  = bus_we && (bus_addr == AD_SEC);
    assign wr_rate = bus_we && (bus_addr == AD_RATE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= '0;
            cfg_q    <= '0;
            shadow_q <= '0;
        end else begin
            cmd_q <= '0;
            if (wr_ctrl) begin
                cfg_q.run     <= bus_wdata[CB_RUN];
                cfg_q.trim_en <= bus_wdata[CB_TRIM];
                cfg_q.step_up <= bus_wdata[CB_SDIR];
                cmd_q.clr     <= bus_wdata[CB_CLR];
                cmd_q.load    <= bus_wdata[CB_LOAD];
                cmd_q.step    <= bus_wdata[CB_STEP];
                cmd_q.snap    <= bus_wdata[CB_SNAP];
            end
            if (wr_rate) begin
                cfg_q.trim_up  <= bus_wdata[RATE_DIR_BIT];
                cfg_q.trim_mag <= bus_wdata[TRIM_W-1:0];
            end
            if (cmd_q.snap) begin
                shadow_q <= live;
            end else begin
                if (wr_ph)  shadow_q.ph  <= bus_wdata[PH_W-1:0];
                if (wr_ns)  shadow_q.ns  <= bus_wdata[NS_W-1:0];
                if (wr_sec) shadow_q.sec <= bus_wdata[SEC_W-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AD_CTRL: begin
                bus_rdata[CB_RUN]  = cfg_q.run;
                bus_rdata[CB_TRIM] = cfg_q.trim_en;
                bus_rdata[CB_SDIR] = cfg_q.step_up;
            end
            AD_PHASE: bus_rdata = DATA_W'(shadow_q.ph);
            AD_NS:    bus_rdata = DATA_W'(shadow_q.ns);
            AD_SEC:   bus_rdata = DATA_W'(shadow_q.sec);
            AD_RATE: begin
                bus_rdata[TRIM_W-1:0]   = cfg_q.trim_mag;
                bus_rdata[RATE_DIR_BIT] = cfg_q.trim_up;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign cmd    = cmd_q;
    assign cfg    = cfg_q;
    assign shadow = shadow_q;

    // R12
    cmd_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> (cmd_q == '0));

    // R7
    snap_copy_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_q.snap |=> (shadow_q == $past(live)));

endmodule

// File: rtl/rtc_frac_accum.sv
module rtc_frac_accum
    import rtc_trim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              load,
    input  logic              run,
    input  logic              trim_en,
    input  logic              trim_up,
    input  logic [TRIM_W-1:0] trim_mag,
    output logic [INC_W-1:0]  inc
);

    logic [FRAC_W-1:0] frac_q;
    logic [FRAC_W:0]   up_sum;
    logic [FRAC_W:0]   dn_dif;
    logic              active;
    logic              carry_tick;
    logic              borrow_tick;

    assign active = run && trim_en;
    assign up_sum = {1'b0, frac_q} + {{(FRAC_W+1-TRIM_W){1'b0}}, trim_mag};
    assign dn_dif = {1'b0, frac_q} - {{(FRAC_W+1-TRIM_W){1'b0}}, trim_mag};
    assign carry_tick  = active && trim_up && up_sum[FRAC_W];
    assign borrow_tick = active && !trim_up && dn_dif[FRAC_W];

    assign inc = INC_W'(NOM_INC) + INC_W'(carry_tick) - INC_W'(borrow_tick);

    always_ff @(posedge clk) begin
        if (rst || clr || load) begin
            frac_q <= '0;
        end else if (active) begin
            frac_q <= trim_up ? up_sum[FRAC_W-1:0] : dn_dif[FRAC_W-1:0];
        end
    end

    // R4
    up_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (active && trim_up && !clr && !load)
        |=> ((frac_q >= $past(frac_q)) == ($past(inc) == INC_W'(NOM_INC))));

    // R5
    dn_borrow_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !trim_up && !clr && !load)
        |=> ((frac_q <= $past(frac_q)) == ($past(inc) == INC_W'(NOM_INC))));

    // R6
    trim_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && !clr && !load) |=> $stable(frac_q));

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_trim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  rtc_cmd_t         cmd,
    input  logic             run,
    input  logic             step_up,
    input  logic [INC_W-1:0] inc,
    input  rtc_time_t        shadow,
    output rtc_time_t        live
);

    rtc_time_t               live_q;
    rtc_time_t               nxt;
    ns_fold_t                fold;
    logic [INC_W-1:0]        tick_inc;
    logic signed [SUM_W-1:0] ns_ext;
    logic signed [SUM_W-1:0] inc_ext;
    logic signed [SUM_W-1:0] stp_mag;
    logic signed [SUM_W-1:0] stp_ext;
    logic [SEC_W-1:0]        sec_adj;
    logic [SEC_W-1:0]        sec_cy;

    always_comb begin
        tick_inc = run ? inc : '0;
        ns_ext   = $signed({3'b000, live_q.ns});
        inc_ext  = $signed({{(SUM_W-INC_W){1'b0}}, tick_inc});
        stp_mag  = $signed({3'b000, shadow.ns});
        if (!cmd.step) begin
            stp_ext = '0;
            sec_adj = '0;
        end else if (step_up) begin
            stp_ext = stp_mag;
            sec_adj = shadow.sec;
        end else begin
            stp_ext = -stp_mag;
            sec_adj = -shadow.sec;
        end
        fold    = fold_ns(ns_ext + inc_ext + stp_ext);
        sec_cy  = {{(SEC_W-2){fold.carry[1]}}, fold.carry};
        nxt.ns  = fold.ns;
        nxt.sec = live_q.sec + sec_adj + sec_cy;
        nxt.ph  = live_q.ph;
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.clr) begin
            live_q <= '0;
        end else if (cmd.load) begin
            live_q <= shadow;
        end else begin
            live_q <= nxt;
        end
    end

    assign live = live_q;

    // R2
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !cmd.clr && !cmd.load && !cmd.step) |=> $stable(live_q));

    // R8
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.load && !cmd.clr) |=> (live_q == $past(shadow)));

    // R11
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.clr |=> (live_q == '0));

endmodule

// File: rtl/rtc_trim_clock.sv
module rtc_trim_clock
    import rtc_trim_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [31:0]       time_sec,
    output logic [29:0]       time_ns,
    output logic [2:0]        time_phase
);

    rtc_cmd_t         cmd;
    rtc_cfg_t         cfg;
    rtc_time_t        shadow;
    rtc_time_t        live;
    logic [INC_W-1:0] inc;

    rtc_regbank #(.ADDR_W(ADDR_W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .live      (live),
        .bus_rdata (bus_rdata),
        .cmd       (cmd),
        .cfg       (cfg),
        .shadow    (shadow)
    );

    rtc_frac_accum frac_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (cmd.clr),
        .load     (cmd.load),
        .run      (cfg.run),
        .trim_en  (cfg.trim_en),
        .trim_up  (cfg.trim_up),
        .trim_mag (cfg.trim_mag),
        .inc      (inc)
    );

    rtc_time_core core_i (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .run     (cfg.run),
        .step_up (cfg.step_up),
        .inc     (inc),
        .shadow  (shadow),
        .live    (live)
    );

    assign time_sec   = live.sec;
    assign time_ns    = live.ns;
    assign time_phase = live.ph;

endmodule

// File: tb/rtc_trim_clock_tb.sv
module rtc_trim_clock_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] time_sec;
    logic [29:0] time_ns;
    logic [2:0]  time_phase;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    rtc_trim_clock dut_i (
        .clk        (clk),
        .rst        (rst),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .time_sec   (time_sec),
        .time_ns    (time_ns),
        .time_phase (time_phase)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    localparam longint TWO32 = 64'h1_0000_0000;
    localparam longint BILL  = 1000000000;
    longint m_sec, m_ns, m_ph, m_frac, m_mag;
    longint sh_sec, sh_ns, sh_ph;
    bit m_run, m_trim, m_up, m_sdir;
    bit p_clr, p_ld, p_st, p_rd;

    always @(posedge clk) begin
        longint inc, nf, s, secd, cy, o_sec, o_ns, o_ph;
        if (rst) begin
            m_sec = 0; m_ns = 0; m_ph = 0; m_frac = 0; m_mag = 0;
            sh_sec = 0; sh_ns = 0; sh_ph = 0;
            m_run = 0; m_trim = 0; m_up = 0; m_sdir = 0;
            p_clr = 0; p_ld = 0; p_st = 0; p_rd = 0;
        end else begin
            inc = 40; nf = m_frac;
            if (m_run && m_trim) begin
                if (m_up) begin
                    nf = m_frac + m_mag;
                    if (nf >= TWO32) begin inc = 41; nf = nf - TWO32; end
                end else begin
                    nf = m_frac - m_mag;
                    if (nf < 0) begin inc = 39; nf = nf + TWO32; end
                end
            end
            o_sec = m_sec; o_ns = m_ns; o_ph = m_ph;
            if (p_clr) begin
                m_sec = 0; m_ns = 0; m_ph = 0; m_frac = 0;
            end else if (p_ld) begin
                m_sec = sh_sec; m_ns = sh_ns; m_ph = sh_ph; m_frac = 0;
            end else begin
                s = m_ns + (m_run ? inc : 0);
                secd = 0;
                if (p_st) begin
                    if (m_sdir) begin s = s + sh_ns; secd = sh_sec; end
                    else begin s = s - sh_ns; secd = -sh_sec; end
                end
                cy = 0;
                if (s >= BILL) begin s = s - BILL; cy = 1; end
                else if (s < 0) begin s = s + BILL; cy = -1; end
                m_ns = s;
                m_sec = (m_sec + secd + cy) & 64'hFFFF_FFFF;
                if (m_run && m_trim) m_frac = nf;
            end
            if (bus_we && bus_addr == 4'h2) sh_ph = bus_wdata[2:0];
            if (bus_we && bus_addr == 4'h4) sh_ns = bus_wdata[29:0];
            if (bus_we && bus_addr == 4'h8) sh_sec = bus_wdata;
            if (p_rd) begin sh_sec = o_sec; sh_ns = o_ns; sh_ph = o_ph; end
            if (bus_we && bus_addr == 4'hC) begin
                m_up = bus_wdata[31]; m_mag = bus_wdata[29:0];
            end
            if (bus_we && bus_addr == 4'h0) begin
                m_run = bus_wdata[1]; m_trim = bus_wdata[2]; m_sdir = bus_wdata[5];
                p_clr = bus_wdata[0]; p_ld = bus_wdata[3];
                p_rd = bus_wdata[4]; p_st = bus_wdata[6];
            end else begin
                p_clr = 0; p_ld = 0; p_rd = 0; p_st = 0;
            end
        end
    end

    // per-cycle comparison against the model (R2, R3, R4, R5, R9, R10)
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 model seconds", time_sec, m_sec);
            chk("R2 model nanoseconds", time_ns, m_ns);
            chk("R2 model phase", time_phase, m_ph);
        end
    end

    // called just after a falling edge; uses exactly one rising edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input longint exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic time_chk(input string tag, input longint s, input longint ns, input longint ph);
        chk({tag, " seconds"}, time_sec, s);
        chk({tag, " nanoseconds"}, time_ns, ns);
        chk({tag, " phase"}, time_phase, ph);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        time_chk("R1 reset", 0, 0, 0);
        rd_chk("R1 ctrl", 4'h0, 0);
        rd_chk("R1 phase", 4'h2, 0);
        rd_chk("R1 ns", 4'h4, 0);
        rd_chk("R1 sec", 4'h8, 0);
        rd_chk("R1 rate", 4'hC, 0);

        // R2 plain run then hold
        wr(4'h0, 32'h02);
        repeat (5) @(negedge clk);
        time_chk("R2 five ticks", 0, 200, 0);
        wr(4'h0, 32'h00);
        repeat (4) @(negedge clk);
        time_chk("R2 stopped hold", 0, 240, 0);

        // R8 load, then R3 wrap
        wr(4'h2, 32'd5);
        wr(4'h4, 32'd999_999_900);
        wr(4'h8, 32'd7);
        wr(4'h0, 32'h0A);
        @(negedge clk);
        time_chk("R8 load", 7, 999_999_900, 5);
        repeat (3) @(negedge clk);
        time_chk("R3 wrap carry", 8, 20, 5);
        wr(4'h0, 32'h00);

        // R7 snapshot of frozen time
        wr(4'h0, 32'h10);
        @(negedge clk);
        rd_chk("R7 shadow sec", 4'h8, 8);
        rd_chk("R7 shadow ns", 4'h4, 60);
        rd_chk("R7 shadow phase", 4'h2, 5);

        // R4 speed-up trim: magnitude 2^29 carries every 8th tick
        wr(4'hC, 32'hA000_0000);
        wr(4'h0, 32'h06);
        repeat (16) @(negedge clk);
        time_chk("R4 trim up 16 ticks", 8, 702, 5);
        wr(4'h0, 32'h00);

        // R5 slow-down trim
        wr(4'hC, 32'h2000_0000);
        wr(4'h0, 32'h06);
        repeat (10) @(negedge clk);
        time_chk("R5 trim down 10 ticks", 8, 1140, 5);
        wr(4'h0, 32'h00);

        // R6 rate ignored with trim disabled
        wr(4'h0, 32'h02);
        repeat (10) @(negedge clk);
        time_chk("R6 trim off 10 ticks", 8, 1580, 5);
        wr(4'h0, 32'h00);

        // R9 step add with nanosecond carry
        wr(4'h8, 32'd3);
        wr(4'h4, 32'd999_999_990);
        wr(4'h0, 32'h60);
        @(negedge clk);
        time_chk("R9 step add", 12, 1610, 5);

        // R10 step subtract with borrow
        wr(4'h8, 32'd2);
        wr(4'h4, 32'd500_000_000);
        wr(4'h0, 32'h40);
        @(negedge clk);
        time_chk("R10 step sub", 9, 500_001_610, 5);

        // R11 clock reset keeps enables
        wr(4'h0, 32'h03);
        @(negedge clk);
        time_chk("R11 cleared", 0, 0, 0);
        rd_chk("R11 enables kept", 4'h0, 32'h02);
        @(negedge clk);
        time_chk("R11 runs after clear", 0, 40, 0);

        // R12 one-shot commands, sticky readback
        wr(4'h0, 32'h56);
        rd_chk("R12 ctrl readback", 4'h0, 32'h06);
        repeat (3) @(negedge clk);
        rd_chk("R12 ctrl still sticky", 4'h0, 32'h06);

        // R13 map and ignored offsets
        rd_chk("R13 rate readback", 4'hC, 32'h2000_0000);
        wr(4'h6, 32'hFFFF_FFFF);
        wr(4'hE, 32'hFFFF_FFFF);
        rd_chk("R13 offset 6 reads zero", 4'h6, 0);
        rd_chk("R13 offset E reads zero", 4'hE, 0);
        rd_chk("R13 rate unchanged", 4'hC, 32'h2000_0000);
        rd_chk("R13 ctrl unchanged", 4'h0, 32'h06);
        rd_chk("R13 shadow ns", 4'h4, sh_ns);
        rd_chk("R13 shadow sec", 4'h8, sh_sec);
        rd_chk("R13 shadow phase", 4'h2, sh_ph);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule